// File: doc/BRIEF.md
# Split Instruction/Data Two-Way Translation Buffer

This block caches page translations for a 32-bit segmented address space. Its storage array is split into a data half and an instruction half, and each half is organised as a number of ways holding a number of sets. An entry stores the effective page number it maps, a first page-table word that carries the valid flag, the hash-table selector and the segment/page match field, and a second word that carries the real page number, the referenced and changed flags and a two-bit protection code.

Software fills entries through a refill port that names the half, the way and the set. A lookup presents an effective address, an access kind, the segment's protection key, the segment's no-execute flag and the match tag for the page. Every way of the selected set is probed in parallel. The registered response reports a hit, a protection fault or a miss, the real address, the effective read/write/execute rights and the updated second page-table word. On a hit or a fault the block also updates the referenced and changed flags of the stored entry, withholding write rights on a page whose changed flag is still clear until a store is granted.

Top module: `xlat_split_tlb`

## Requirements
- R1: The set is ea[16:12] and way w of a half lives at set + 32*w. Loads and stores search only the data half and fetches search only the instruction half. A refill with fill_ihalf=1 writes the instruction half and one with fill_ihalf=0 writes the data half.
- R2: An entry is a candidate only when its stored page number equals ea[31:12].
- R3: A candidate matches only when its first word has bit 31 (valid) set, bit 6 (hash selector) clear, and {bits 30:7, bits 5:0} equal to lk_tag.
- R4: Rights come from the protection code pp = second word bits 1:0. With key 0, pp 0, 1 and 2 give read+write and pp 3 gives read only. With key 1, pp 0 gives nothing, pp 1 and 3 give read only and pp 2 gives read+write. Execute is given when some access is given and lk_noexec is 0. Access kind 00 is a load and needs read, 01 is a store and needs write, 10 is a fetch and needs execute, 11 behaves as a load.
- R5: The lowest-numbered matching way that grants the access gives a hit. When no way grants, the highest-numbered matching way gives a fault and supplies the rights and words. When nothing matches, the result is a miss.
- R6: On a hit or a fault, bit 8 (referenced) of the stored second word is set, and rsp_pte1 returns the updated word.
- R7: Bit 7 (changed) of the stored word is set on a granted store. Otherwise, when bit 7 was clear, the reported write right is cleared.
- R8: The response appears one clock after the lookup with rsp_valid=1. rsp_raddr = {second word bits 31:12, ea[11:0]}. On a miss, the rights, rsp_raddr and rsp_pte1 are all zero.
- R9: A refill in the same cycle as a lookup takes priority. The lookup gets no response and makes no flag update, and the refill is written.
- R10: After reset rsp_valid is 0 and every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Refill write strobe |
| fill_ihalf | input | 1 | Refill target half: 1 instruction, 0 data |
| fill_way | input | 1 | Refill way |
| fill_set | input | 5 | Refill set |
| fill_epn | input | 20 | Effective page number stored in the entry |
| fill_pte0 | input | 32 | First page-table word (valid, match field, hash selector) |
| fill_pte1 | input | 32 | Second page-table word (page number, flags, protection) |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| lk_key | input | 1 | Segment protection key |
| lk_noexec | input | 1 | Segment forbids execution |
| lk_tag | input | 30 | Expected segment/page match tag |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Access granted |
| rsp_fault | output | 1 | Matching entry denied the access |
| rsp_raddr | output | 32 | Real address |
| rsp_rd | output | 1 | Read right |
| rsp_wr | output | 1 | Write right after the changed-flag rule |
| rsp_ex | output | 1 | Execute right |
| rsp_pte1 | output | 32 | Second page-table word after the flag update |

## Verification
The bench builds the block with its defaults of two ways and 32 sets per way in each half. Two ways are the smallest count that lets one set hold a denying way beside a granting one, or two denying ways, so both orders of the way priority and the choice of fault way can be reached. With 32 sets and a narrow random pool of page numbers and tags, random refills keep colliding in the same sets and halves. This drives hits, faults, misses and repeated flag updates to the same entry, and the results are compared with a reference model kept in the bench.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
  localparam int PTE_W = 32;

  localparam logic [1:0] ACC_LOAD  = 2'b00;
  localparam logic [1:0] ACC_STORE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  localparam int P0_VALID = 31;
  localparam int P0_HSEL  = 6;
  localparam int P1_REF   = 8;
  localparam int P1_CHG   = 7;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  function automatic rights_t pp_rights(input logic key, input logic [1:0] pp,
                                        input logic nx);
    rights_t r;
    r.rd = key ? (pp != 2'd0) : 1'b1;
    r.wr = key ? (pp == 2'd2) : (pp != 2'd3);
    r.ex = r.rd & ~nx;
    return r;
  endfunction
endpackage

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store #(
  parameter int ENTRIES  = 128,
  parameter int EPN_W    = 20,
  parameter int RD_PORTS = 2,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [EPN_W-1:0]              wr_epn,
  input  logic [xlat_tlb_pkg::PTE_W-1:0] wr_pte0,
  input  logic [xlat_tlb_pkg::PTE_W-1:0] wr_pte1,
  input  logic                          upd_en,
  input  logic [IDX_W-1:0]              upd_idx,
  input  logic [xlat_tlb_pkg::PTE_W-1:0] upd_pte1,
  input  logic [IDX_W-1:0]              rd_idx  [RD_PORTS],
  output logic [EPN_W-1:0]              rd_epn  [RD_PORTS],
  output logic [xlat_tlb_pkg::PTE_W-1:0] rd_pte0 [RD_PORTS],
  output logic [xlat_tlb_pkg::PTE_W-1:0] rd_pte1 [RD_PORTS]
);
  import xlat_tlb_pkg::*;

  logic [EPN_W-1:0] epn_arr [ENTRIES];
  logic [PTE_W-1:0] p0_arr  [ENTRIES];
  logic [PTE_W-1:0] p1_arr  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [EPN_W-1:0] epn_q, epn_d;
    logic [PTE_W-1:0] p0_q, p0_d, p1_q, p1_d;
    logic             wsel, usel, ent_en;

    assign wsel   = wr_en && (wr_idx == IDX_W'(e));
    assign usel   = upd_en && (upd_idx == IDX_W'(e));
    assign ent_en = wsel | usel;

    always_comb begin
      epn_d = epn_q;
      p0_d  = p0_q;
      p1_d  = p1_q;
      if (wsel) begin
        epn_d = wr_epn;
        p0_d  = wr_pte0;
        p1_d  = wr_pte1;
      end else if (usel) begin
        p1_d  = upd_pte1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        epn_q <= '0;
        p0_q  <= '0;
        p1_q  <= '0;
      end else if (ent_en) begin
        epn_q <= epn_d;
        p0_q  <= p0_d;
        p1_q  <= p1_d;
      end
    end

    assign epn_arr[e] = epn_q;
    assign p0_arr[e]  = p0_q;
    assign p1_arr[e]  = p1_q;
  end

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
    assign rd_epn[r]  = epn_arr[rd_idx[r]];
    assign rd_pte0[r] = p0_arr[rd_idx[r]];
    assign rd_pte1[r] = p1_arr[rd_idx[r]];
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && upd_en)); // R9
endmodule

// File: rtl/xlat_tlb_way_eval.sv
module xlat_tlb_way_eval #(
  parameter int EPN_W = 20
) (
  input  logic [EPN_W-1:0]                page_num,
  input  logic [EPN_W-1:0]                ent_epn,
  input  logic [xlat_tlb_pkg::PTE_W-1:0]  pte0,
  input  logic [xlat_tlb_pkg::PTE_W-1:0]  pte1,
  input  logic [29:0]                     tag,
  input  logic                            key,
  input  logic                            nx,
  input  logic [1:0]                      kind,
  output logic                            match,
  output logic                            grant,
  output xlat_tlb_pkg::rights_t           rights
);
  import xlat_tlb_pkg::*;

  logic cand;
  logic need;

  assign cand   = (ent_epn == page_num);
  assign match  = cand && pte0[P0_VALID] && !pte0[P0_HSEL] &&
                  ({pte0[30:7], pte0[5:0]} == tag);
  assign rights = pp_rights(key, pte1[1:0], nx);

  always_comb begin
    unique case (kind)
      ACC_STORE: need = rights.wr;
      ACC_FETCH: need = rights.ex;
      default:   need = rights.rd;
    endcase
  end

  assign grant = match && need;
endmodule

// File: rtl/xlat_tlb_pick.sv
module xlat_tlb_pick #(
  parameter int WAYS = 2,
  localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0] match,
  input  logic [WAYS-1:0] grant,
  output logic            hit,
  output logic            fault,
  output logic [WW-1:0]   sel
);
  logic found;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (grant[w] && !found) begin
        found = 1'b1;
        sel   = WW'(w);
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (match[w]) sel = WW'(w);
      end
    end
    hit   = found;
    fault = !found && (|match);
  end

  always_comb begin
    AST_PICK_EXCL: assert (!(hit && fault)); // R5
  end
endmodule

// File: rtl/xlat_split_tlb.sv
module xlat_split_tlb #(
  parameter int WAYS      = 2,
  parameter int SETS      = 32,
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  localparam int SET_W    = $clog2(SETS),
  localparam int WW       = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int EPN_W    = AW - PAGE_BITS,
  localparam int HALF     = WAYS * SETS,
  localparam int ENTRIES  = 2 * HALF,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic             fill_ihalf,
  input  logic [WW-1:0]    fill_way,
  input  logic [SET_W-1:0] fill_set,
  input  logic [EPN_W-1:0] fill_epn,
  input  logic [31:0]      fill_pte0,
  input  logic [31:0]      fill_pte1,
  input  logic             lk_valid,
  input  logic [AW-1:0]    lk_ea,
  input  logic [1:0]       lk_kind,
  input  logic             lk_key,
  input  logic             lk_noexec,
  input  logic [29:0]      lk_tag,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [AW-1:0]    rsp_raddr,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             rsp_ex,
  output logic [31:0]      rsp_pte1
);
  import xlat_tlb_pkg::*;

  logic [EPN_W-1:0] page_num;
  logic [SET_W-1:0] lk_set;
  logic             is_fetch, is_store, do_lk;

  assign page_num = lk_ea[AW-1:PAGE_BITS];
  assign lk_set   = lk_ea[PAGE_BITS +: SET_W];
  assign is_fetch = (lk_kind == ACC_FETCH);
  assign is_store = (lk_kind == ACC_STORE);
  assign do_lk    = lk_valid && !fill_en;

  logic [IDX_W-1:0] fill_idx;
  assign fill_idx = IDX_W'(fill_set) + IDX_W'(fill_way) * IDX_W'(SETS) +
                    (fill_ihalf ? IDX_W'(HALF) : IDX_W'(0));

  logic [IDX_W-1:0] rd_idx  [WAYS];
  logic [EPN_W-1:0] rd_epn  [WAYS];
  logic [PTE_W-1:0] rd_pte0 [WAYS];
  logic [PTE_W-1:0] rd_pte1 [WAYS];
  logic [WAYS-1:0]  way_match, way_grant;
  rights_t          way_rt  [WAYS];

  logic             upd_en;
  logic [IDX_W-1:0] upd_idx;
  logic [PTE_W-1:0] upd_pte1;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign rd_idx[w] = IDX_W'(lk_set) + IDX_W'(w * SETS) +
                       (is_fetch ? IDX_W'(HALF) : IDX_W'(0));

    xlat_tlb_way_eval #(.EPN_W(EPN_W)) u_eval (
      .page_num (page_num),
      .ent_epn  (rd_epn[w]),
      .pte0     (rd_pte0[w]),
      .pte1     (rd_pte1[w]),
      .tag      (lk_tag),
      .key      (lk_key),
      .nx       (lk_noexec),
      .kind     (lk_kind),
      .match    (way_match[w]),
      .grant    (way_grant[w]),
      .rights   (way_rt[w])
    );
  end

  xlat_tlb_store #(.ENTRIES(ENTRIES), .EPN_W(EPN_W), .RD_PORTS(WAYS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fill_en),
    .wr_idx   (fill_idx),
    .wr_epn   (fill_epn),
    .wr_pte0  (fill_pte0),
    .wr_pte1  (fill_pte1),
    .upd_en   (upd_en),
    .upd_idx  (upd_idx),
    .upd_pte1 (upd_pte1),
    .rd_idx   (rd_idx),
    .rd_epn   (rd_epn),
    .rd_pte0  (rd_pte0),
    .rd_pte1  (rd_pte1)
  );

  logic          pk_hit, pk_fault;
  logic [WW-1:0] pk_sel;

  xlat_tlb_pick #(.WAYS(WAYS)) u_pick (
    .match (way_match),
    .grant (way_grant),
    .hit   (pk_hit),
    .fault (pk_fault),
    .sel   (pk_sel)
  );

  logic [PTE_W-1:0] sel_pte1;
  rights_t          sel_rt, out_rt;
  logic             any_match, set_chg;

  assign sel_pte1  = rd_pte1[pk_sel];
  assign sel_rt    = way_rt[pk_sel];
  assign any_match = pk_hit | pk_fault;
  assign set_chg   = pk_hit && is_store;

  assign upd_en   = do_lk && any_match;
  assign upd_idx  = rd_idx[pk_sel];

  always_comb begin
    upd_pte1 = sel_pte1;
    upd_pte1[P1_REF] = 1'b1;
    if (set_chg) upd_pte1[P1_CHG] = 1'b1;
    out_rt    = sel_rt;
    out_rt.wr = sel_rt.wr && (sel_pte1[P1_CHG] || set_chg);
  end

  // response next state
  logic          hit_d, fault_d, rd_d, wr_d, ex_d;
  logic [AW-1:0] raddr_d;
  logic [31:0]   p1_d;

  always_comb begin
    hit_d   = 1'b0;
    fault_d = 1'b0;
    rd_d    = 1'b0;
    wr_d    = 1'b0;
    ex_d    = 1'b0;
    raddr_d = '0;
    p1_d    = '0;
    if (any_match) begin
      hit_d   = pk_hit;
      fault_d = pk_fault;
      rd_d    = out_rt.rd;
      wr_d    = out_rt.wr;
      ex_d    = out_rt.ex;
      raddr_d = {sel_pte1[PTE_W-1:PAGE_BITS], lk_ea[PAGE_BITS-1:0]};
      p1_d    = upd_pte1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= do_lk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
      rsp_raddr <= '0;
      rsp_pte1  <= '0;
    end else if (do_lk) begin
      rsp_hit   <= hit_d;
      rsp_fault <= fault_d;
      rsp_rd    <= rd_d;
      rsp_wr    <= wr_d;
      rsp_ex    <= ex_d;
      rsp_raddr <= raddr_d;
      rsp_pte1  <= p1_d;
    end
  end

  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_fault)); // R5
  AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !rsp_valid); // R9
  AST_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_hit || rsp_fault)) |-> rsp_pte1[P1_REF]); // R6
  AST_WRITE_NEEDS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr) |-> rsp_pte1[P1_CHG]); // R7
  AST_NX_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !fill_en && lk_noexec) |=> !rsp_ex); // R4
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && !rsp_fault) |-> (!rsp_rd && !rsp_wr && !rsp_ex)); // R8
endmodule

// File: tb/tb_xlat_split_tlb.sv
module tb_xlat_split_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 2;
  localparam int NS = 32;
  localparam int NE = 2 * NW * NS;

  logic        clk, rst_n;
  logic        fill_en, fill_ihalf;
  logic [0:0]  fill_way;
  logic [4:0]  fill_set;
  logic [19:0] fill_epn;
  logic [31:0] fill_pte0, fill_pte1;
  logic        lk_valid;
  logic [31:0] lk_ea;
  logic [1:0]  lk_kind;
  logic        lk_key, lk_noexec;
  logic [29:0] lk_tag;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_rd, rsp_wr, rsp_ex;
  logic [31:0] rsp_raddr, rsp_pte1;

  int n_chk = 0;
  int n_bad = 0;

  logic [19:0] m_epn [NE];
  logic [31:0] m_p0  [NE];
  logic [31:0] m_p1  [NE];

  xlat_split_tlb dut (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_ihalf(fill_ihalf), .fill_way(fill_way),
    .fill_set(fill_set), .fill_epn(fill_epn), .fill_pte0(fill_pte0),
    .fill_pte1(fill_pte1),
    .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_kind(lk_kind), .lk_key(lk_key),
    .lk_noexec(lk_noexec), .lk_tag(lk_tag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_raddr(rsp_raddr), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
    .rsp_pte1(rsp_pte1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  // rights {rd,wr,ex} from key, pp, noexec (R4 table)
  function automatic logic [2:0] f_rights(logic key, logic [1:0] pp, logic nx);
    logic rd, wr;
    case ({key, pp})
      3'b0_00, 3'b0_01, 3'b0_10: begin rd = 1; wr = 1; end
      3'b0_11:                   begin rd = 1; wr = 0; end
      3'b1_00:                   begin rd = 0; wr = 0; end
      3'b1_10:                   begin rd = 1; wr = 1; end
      default:                   begin rd = 1; wr = 0; end
    endcase
    return {rd, wr, rd & ~nx};
  endfunction

  function automatic int f_idx(logic ihalf, int way, logic [4:0] set);
    return int'(set) + NS * way + (ihalf ? NW * NS : 0);
  endfunction

  task automatic chk(string req, logic [68:0] got, logic [68:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk1(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic refill(logic ih, int way, logic [4:0] set, logic [19:0] epn,
                        logic [31:0] p0, logic [31:0] p1);
    @(negedge clk);
    fill_en = 1; fill_ihalf = ih; fill_way = 1'(way); fill_set = set;
    fill_epn = epn; fill_pte0 = p0; fill_pte1 = p1;
    @(posedge clk); #1;
    fill_en = 0;
    m_epn[f_idx(ih, way, set)] = epn;
    m_p0[f_idx(ih, way, set)]  = p0;
    m_p1[f_idx(ih, way, set)]  = p1;
  endtask

  task automatic lookup(string req, logic [31:0] ea, logic [1:0] kind,
                        logic key, logic nx, logic [29:0] tag);
    logic ih, found, any;
    logic [2:0] rt, need_rt;
    int sel, idx;
    logic [31:0] p1n;
    logic [68:0] exp;
    ih = (kind == 2'b10);
    found = 0; any = 0; sel = 0;
    for (int w = 0; w < NW; w++) begin
      int i;
      logic m, g;
      i = f_idx(ih, w, ea[16:12]);
      m = (m_epn[i] == ea[31:12]) && m_p0[i][31] && !m_p0[i][6] &&
          ({m_p0[i][30:7], m_p0[i][5:0]} == tag);
      rt = f_rights(key, m_p1[i][1:0], nx);
      g = m && ((kind == 2'b01) ? rt[1] : (kind == 2'b10) ? rt[0] : rt[2]);
      if (g && !found) begin found = 1; sel = w; end
    end
    if (!found)
      for (int w = 0; w < NW; w++) begin
        int i;
        i = f_idx(ih, w, ea[16:12]);
        if ((m_epn[i] == ea[31:12]) && m_p0[i][31] && !m_p0[i][6] &&
            ({m_p0[i][30:7], m_p0[i][5:0]} == tag)) begin any = 1; sel = w; end
      end
    any = any | found;
    idx = f_idx(ih, sel, ea[16:12]);
    exp = '0;
    if (any) begin
      need_rt = f_rights(key, m_p1[idx][1:0], nx);
      p1n = m_p1[idx] | 32'h100 | ((found && kind == 2'b01) ? 32'h80 : 32'h0);
      if (!m_p1[idx][7] && !(found && kind == 2'b01)) need_rt[1] = 0;
      exp = {found, !found, need_rt, m_p1[idx][31:12], ea[11:0], p1n};
      m_p1[idx] = p1n;
    end
    @(negedge clk);
    lk_valid = 1; lk_ea = ea; lk_kind = kind; lk_key = key; lk_noexec = nx;
    lk_tag = tag;
    @(posedge clk); #1;
    lk_valid = 0;
    chk1({req, " rsp_valid"}, rsp_valid, 1'b1);
    chk(req, {rsp_hit, rsp_fault, rsp_rd, rsp_wr, rsp_ex, rsp_raddr, rsp_pte1}, exp);
  endtask

  function automatic logic [31:0] mk_p0(logic v, logic [29:0] tag, logic h);
    return {v, tag[29:6], h, tag[5:0]};
  endfunction

  localparam logic [29:0] T1 = 30'h1234567;
  localparam logic [29:0] T2 = 30'h0ABCDE5;

  initial begin
    logic [19:0] epool [8];
    logic [29:0] tpool [4];
    void'($urandom(32'd2024));
    for (int i = 0; i < NE; i++) begin m_epn[i] = '0; m_p0[i] = '0; m_p1[i] = '0; end
    rst_n = 0; fill_en = 0; fill_ihalf = 0; fill_way = 0; fill_set = 0;
    fill_epn = 0; fill_pte0 = 0; fill_pte1 = 0; lk_valid = 0; lk_ea = 0;
    lk_kind = 0; lk_key = 0; lk_noexec = 0; lk_tag = 0;
    repeat (3) @(posedge clk);
    #1 chk1("R10 rsp_valid in reset", rsp_valid, 1'b0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1 chk1("R10 rsp_valid after reset", rsp_valid, 1'b0);
    lookup("R10 empty load miss", 32'h00000000, 2'b00, 0, 0, 30'h0);
    lookup("R10 empty fetch miss", 32'h00005123, 2'b10, 0, 0, 30'h0);

    // R1/R2: data half entry, fetch misses, wrong page number misses
    refill(0, 0, 5'd5, 20'h00005, mk_p0(1, T1, 0), 32'hAAAA_A182);
    lookup("R1 R8 data load hit", 32'h00005ABC, 2'b00, 0, 0, T1);
    lookup("R1 fetch sees instruction half only", 32'h00005ABC, 2'b10, 0, 0, T1);
    lookup("R2 page number mismatch", 32'h00025ABC, 2'b00, 0, 0, T1);
    // R3: hash selector set, wrong tag, invalid
    refill(0, 0, 5'd6, 20'h00006, mk_p0(1, T1, 1), 32'h1111_1182);
    lookup("R3 hash selector set misses", 32'h00006000, 2'b00, 0, 0, T1);
    lookup("R3 wrong tag misses", 32'h00005000, 2'b00, 0, 0, T2);
    refill(0, 1, 5'd6, 20'h00006, mk_p0(0, T1, 0), 32'h1111_1182);
    lookup("R3 invalid entry misses", 32'h00006000, 2'b00, 0, 0, T1);
    // R5: way0 denies store, way1 grants
    refill(0, 0, 5'd7, 20'h00007, mk_p0(1, T1, 0), 32'h0000_7083);
    refill(0, 1, 5'd7, 20'h00007, mk_p0(1, T1, 0), 32'h0001_7082);
    lookup("R5 later way grants", 32'h00007010, 2'b01, 0, 0, T1);
    refill(0, 0, 5'd8, 20'h00008, mk_p0(1, T1, 0), 32'h0000_8083);
    refill(0, 1, 5'd8, 20'h00008, mk_p0(1, T1, 0), 32'h0002_8083);
    lookup("R5 both deny fault from last way", 32'h00008010, 2'b01, 0, 0, T1);
    lookup("R5 R6 first grant wins", 32'h00008010, 2'b00, 0, 0, T1);
    // R7: changed flag
    refill(0, 0, 5'd9, 20'h00009, mk_p0(1, T2, 0), 32'h0000_9002);
    lookup("R7 R6 load before any store", 32'h00009004, 2'b00, 0, 0, T2);
    lookup("R7 granted store sets changed", 32'h00009004, 2'b01, 0, 0, T2);
    lookup("R7 load after store", 32'h00009004, 2'b00, 0, 0, T2);
    // R4: execute and key
    refill(1, 0, 5'd10, 20'h0000A, mk_p0(1, T1, 0), 32'h0000_A182);
    lookup("R4 noexec fetch faults", 32'h0000A000, 2'b10, 0, 1, T1);
    lookup("R4 fetch allowed", 32'h0000A000, 2'b10, 0, 0, T1);
    refill(0, 1, 5'd10, 20'h0000A, mk_p0(1, T1, 0), 32'h0000_B180);
    lookup("R4 key1 pp0 denies load", 32'h0000A000, 2'b00, 1, 0, T1);
    lookup("R4 key0 pp0 allows store", 32'h0000A000, 2'b01, 0, 0, T1);
    // R9: refill with a concurrent store lookup
    refill(0, 0, 5'd11, 20'h0000B, mk_p0(1, T2, 0), 32'h0000_C002);
    @(negedge clk);
    fill_en = 1; fill_ihalf = 0; fill_way = 1; fill_set = 5'd12;
    fill_epn = 20'h0000C; fill_pte0 = mk_p0(1, T2, 0); fill_pte1 = 32'h0000_D182;
    lk_valid = 1; lk_ea = 32'h0000B000; lk_kind = 2'b01; lk_key = 0;
    lk_noexec = 0; lk_tag = T2;
    @(posedge clk); #1;
    fill_en = 0; lk_valid = 0;
    m_epn[f_idx(0, 1, 5'd12)] = 20'h0000C;
    m_p0[f_idx(0, 1, 5'd12)] = mk_p0(1, T2, 0);
    m_p1[f_idx(0, 1, 5'd12)] = 32'h0000_D182;
    chk1("R9 lookup dropped", rsp_valid, 1'b0);
    lookup("R9 dropped store left changed clear", 32'h0000B000, 2'b00, 0, 0, T2);
    lookup("R9 refill written", 32'h0000C000, 2'b00, 0, 0, T2);

    // random phase
    for (int i = 0; i < 8; i++) epool[i] = {12'hC30, 3'($urandom_range(0, 3)), 5'($urandom_range(16, 19))};
    for (int i = 0; i < 4; i++) tpool[i] = 30'($urandom);
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [19:0] e;
        logic [29:0] t;
        e = epool[$urandom_range(0, 7)];
        t = tpool[$urandom_range(0, 3)];
        refill(1'($urandom_range(0, 1)), $urandom_range(0, 1), e[4:0], e,
               mk_p0($urandom_range(0, 7) != 0, t, $urandom_range(0, 7) == 0),
               32'($urandom) & 32'hFFFF_F183);
      end else begin
        logic [19:0] e;
        e = epool[$urandom_range(0, 7)];
        lookup("R1 R5 R6 R7 random", {e, 12'($urandom)}, 2'($urandom_range(0, 2)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               tpool[$urandom_range(0, 3)]);
      end
    end
    summary();
    $finish;
  end
endmodule